// File: doc/BRIEF.md
# Split-Word Host RAM Port

This block gives a host processor strobe-driven access to an on-chip memory of 24-bit words. It runs in one of two access views. The full view moves a whole word per access. The split view divides each word into a 16-bit low field and an 8-bit high field and moves one of them per access, which suits a 16-bit host bus. Every input, including the active-low read and write strobes, is sampled by a fast system clock. Each strobe passes through two synchroniser flops before its edges are detected, so the design contains no strobe-clocked logic.

The falling edge of a strobe captures the address and the field select. A read loads the chosen view of the word into an output register and drives the bus for as long as the read strobe stays low. A write holds the captured address and keeps following the data bus while the strobe is low. It commits on the rising edge of the write strobe, and in the split view it changes only the selected field. Strobe pulses must be at least three system clocks wide. The address and field select must stay stable for two system clocks after a falling strobe. Write data must stay stable for two system clocks after the write strobe rises.

Top module: `split_word_ram_port`

## Requirements
- R1: With `split_mode` = 0 (full view), a read returns all 24 bits of the addressed word on `dq_out`, whatever the level of `upper_sel`.
- R2: With `split_mode` = 0, a write stores all 24 bits of `dq_in` into the addressed word, whatever the level of `upper_sel`.
- R3: With `split_mode` = 1 and `upper_sel` = 0, a write replaces word bits 15..0 with `dq_in[15:0]` and leaves word bits 23..16 unchanged.
- R4: With `split_mode` = 1 and `upper_sel` = 1, a write replaces word bits 23..16 with `dq_in[7:0]` and leaves word bits 15..0 unchanged.
- R5: With `split_mode` = 1 and `upper_sel` = 0, a read returns word bits 15..0 on `dq_out[15:0]` and zeros on `dq_out[23:16]`.
- R6: With `split_mode` = 1 and `upper_sel` = 1, a read returns word bits 23..16 on `dq_out[7:0]` and zeros on `dq_out[23:8]`.
- R7: The address and field select in force when a strobe falls set the access. Changing them while the strobe stays low changes neither the read value being driven nor the word that is written.
- R8: A write stores the last data presented before the write strobe rises. Data shown earlier in the same pulse is discarded.
- R9: `dq_oe` rises on the third clock edge after `rd_n` falls and falls on the third clock edge after `rd_n` rises. `dq_out` is zero whenever `dq_oe` is low and stays unchanged while `dq_oe` is high.
- R10: After reset `dq_oe` is low, `dq_out` is zero and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| split_mode | input | 1 | 0 selects the full 24-bit view, 1 selects the 16/8 split view |
| addr_in | input | ADDR_W | Word address, captured on a falling strobe |
| upper_sel | input | 1 | Split-view field select: 0 selects the low 16 bits, 1 the high 8 bits |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dq_in | input | DATA_W | Inbound half of the bidirectional data bus |
| dq_out | output | DATA_W | Outbound half of the data bus |
| dq_oe | output | 1 | High while the block drives the data bus |

## Verification
The bench builds the block with ADDR_W = 4 and keeps the default 24-bit word and 16-bit low field. The store then has sixteen words. A full sweep of writes and reads-back covers the lowest and highest address and the address-wrap corner in a few hundred clocks. Because the field widths stay at their default values, the zero-fill positions and field placements in R3 to R6 are checked exactly as a host would see them.

// File: rtl/sport_pkg.sv
// Shared encodings for the split-word host RAM port.
// Assumes the low field is at least as wide as the high field.
package sport_pkg;

    // Access view chosen by the split_mode input
    typedef enum logic {
        VIEW_FULL  = 1'b0,
        VIEW_SPLIT = 1'b1
    } view_e;

    // Field chosen by the upper_sel input in the split view
    typedef enum logic {
        FIELD_LOW  = 1'b0,
        FIELD_HIGH = 1'b1
    } field_e;

endpackage

// File: rtl/sport_strobe_sync.sv
// Strobe synchroniser and edge detector.
// Passes an active-low strobe and its payload through two flops and
// compares the second stage with a third to give one-cycle fall and
// rise pulses. The payload stays aligned with the second strobe stage.
// Assumes strobe pulses last at least three clocks.
module sport_strobe_sync #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_n,
    input  logic [PW-1:0] payload_in,
    output logic [PW-1:0] payload_q,
    output logic          fell,
    output logic          rose
);
    logic          s1, s2, s3;
    logic [PW-1:0] p1;

    // Synchronise the strobe and keep its previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= strobe_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Delay the payload alongside the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1        <= '0;
            payload_q <= '0;
        end else begin
            p1        <= payload_in;
            payload_q <= p1;
        end
    end

    assign fell = s3 & ~s2;
    assign rose = ~s3 & s2;
endmodule

// File: rtl/sport_word_store.sv
// Word store with a bit-masked write port and a combinational read port.
// All words are cleared by reset.
module sport_word_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise merge masked bits into the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sport_rd_view.sv
// Read formatter: places the selected part of a word on the low bus lines
// and fills the lines above it with zeros. The full view passes the word through.
module sport_rd_view
    import sport_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int LOW_W  = 16
) (
    input  view_e             view,
    input  field_e            field,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] bus
);
    localparam int HIGH_W = DATA_W - LOW_W;

    // Pick the field and zero-fill the unused lines
    always_comb begin
        bus = '0;
        if (view == VIEW_FULL)
            bus = word;
        else if (field == FIELD_LOW)
            bus[LOW_W-1:0] = word[LOW_W-1:0];
        else
            bus[HIGH_W-1:0] = word[DATA_W-1:LOW_W];
    end
endmodule

// File: rtl/sport_wr_lanes.sv
// Write lane steering: places bus data onto the word field being written
// and builds the bit mask that protects the rest of the word.
module sport_wr_lanes
    import sport_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int LOW_W  = 16
) (
    input  view_e             view,
    input  field_e            field,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] wmask
);
    localparam int HIGH_W = DATA_W - LOW_W;

    // Steer data and enable only the target bits
    always_comb begin
        wdata = '0;
        wmask = '0;
        if (view == VIEW_FULL) begin
            wdata = bus;
            wmask = '1;
        end else if (field == FIELD_LOW) begin
            wdata[LOW_W-1:0] = bus[LOW_W-1:0];
            wmask[LOW_W-1:0] = '1;
        end else begin
            wdata[DATA_W-1:LOW_W] = bus[HIGH_W-1:0];
            wmask[DATA_W-1:LOW_W] = '1;
        end
    end
endmodule

// File: rtl/split_word_ram_port.sv
// Split-word host RAM port (top).
// Gives strobe-driven host access to a store of DATA_W-bit words in a
// full view or a split low/high field view. A falling strobe captures the
// address and field select. A read drives its formatted word until rd_n
// rises. A write commits the last data seen at the rising edge of wr_n.
// Assumes strobes of at least three clocks and address, select and data
// held stable for two clocks after the sampling edges.
module split_word_ram_port
    import sport_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24,
    parameter int LOW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              upper_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int RD_PW = 1 + ADDR_W;
    localparam int WR_PW = 1 + ADDR_W + DATA_W;

    logic [RD_PW-1:0]  rd_p;
    logic [WR_PW-1:0]  wr_p;
    logic              rd_fell, rd_rose, wr_fell, wr_rose;
    logic [DATA_W-1:0] store_rdata, rd_bus;
    logic              rd_active;
    logic [DATA_W-1:0] rd_word_q;
    logic              wr_armed, wr_split_q, wr_sel_q, wr_we;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q, wr_wdata, wr_mask;

    sport_strobe_sync #(.PW(RD_PW)) i_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_n),
        .payload_in({upper_sel, addr_in}),
        .payload_q(rd_p), .fell(rd_fell), .rose(rd_rose)
    );

    sport_strobe_sync #(.PW(WR_PW)) i_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(wr_n),
        .payload_in({upper_sel, addr_in, dq_in}),
        .payload_q(wr_p), .fell(wr_fell), .rose(wr_rose)
    );

    sport_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_we), .waddr(wr_addr_q), .wdata(wr_wdata), .wmask(wr_mask),
        .raddr(rd_p[ADDR_W-1:0]), .rdata(store_rdata)
    );

    sport_rd_view #(.DATA_W(DATA_W), .LOW_W(LOW_W)) i_rd_view (
        .view(view_e'(split_mode)), .field(field_e'(rd_p[ADDR_W])),
        .word(store_rdata), .bus(rd_bus)
    );

    sport_wr_lanes #(.DATA_W(DATA_W), .LOW_W(LOW_W)) i_wr_lanes (
        .view(view_e'(wr_split_q)), .field(field_e'(wr_sel_q)),
        .bus(wr_data_q), .wdata(wr_wdata), .wmask(wr_mask)
    );

    // Read side: capture the formatted word on fall, release the bus on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            rd_word_q <= '0;
        end else if (rd_fell) begin
            rd_active <= 1'b1;
            rd_word_q <= rd_bus;
        end else if (rd_rose) begin
            rd_active <= 1'b0;
            rd_word_q <= '0;
        end
    end

    // Write side: latch target on fall, follow data while low, disarm on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_armed   <= 1'b0;
            wr_split_q <= 1'b0;
            wr_sel_q   <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else if (wr_fell) begin
            wr_armed   <= 1'b1;
            wr_split_q <= split_mode;
            wr_sel_q   <= wr_p[WR_PW-1];
            wr_addr_q  <= wr_p[DATA_W +: ADDR_W];
            wr_data_q  <= wr_p[DATA_W-1:0];
        end else if (wr_rose) begin
            wr_armed   <= 1'b0;
        end else if (wr_armed) begin
            wr_data_q  <= wr_p[DATA_W-1:0];
        end
    end

    assign wr_we  = wr_rose & wr_armed;
    assign dq_out = rd_word_q;
    assign dq_oe  = rd_active;
endmodule

// File: rtl/split_word_ram_port_chk.sv
// Protocol checker for the split-word host RAM port, bound to the top.
module split_word_ram_port_chk #(
    parameter int DATA_W = 24,
    parameter int LOW_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              wr_we,
    input logic              wr_split_q,
    input logic              wr_sel_q,
    input logic [DATA_W-1:0] wr_mask
);
    // R9
    oe_rise_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(rd_n, 2) == 1'b0));

    // R9
    oe_fall_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> ($past(rd_n, 2) == 1'b1));

    // R7
    driven_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    // R2
    full_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_we && !wr_split_q) |-> (&wr_mask));

    // R3
    low_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_we && wr_split_q && !wr_sel_q) |->
            ((wr_mask[DATA_W-1:LOW_W] == '0) && (&wr_mask[LOW_W-1:0])));

    // R4
    high_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_we && wr_split_q && wr_sel_q) |->
            ((wr_mask[LOW_W-1:0] == '0) && (&wr_mask[DATA_W-1:LOW_W])));
endmodule

bind split_word_ram_port split_word_ram_port_chk #(.DATA_W(DATA_W), .LOW_W(LOW_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .wr_we(wr_we), .wr_split_q(wr_split_q), .wr_sel_q(wr_sel_q), .wr_mask(wr_mask)
);

// File: tb/test_split_word_ram_port.sv
`timescale 1ns/1ps
module test_split_word_ram_port;
    localparam int AW    = 4;
    localparam int DW    = 24;
    localparam int LW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          split_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          upper_sel = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    split_word_ram_port #(.ADDR_W(AW), .DATA_W(DW), .LOW_W(LW)) i_split_word_ram_port (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .addr_in(addr_in),
        .upper_sel(upper_sel), .rd_n(rd_n), .wr_n(wr_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    int            n_cmp = 0;
    int            n_bad = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic          oe_prev = 1'b0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Expected bus view of a word, taken from R1, R5 and R6
    function automatic logic [DW-1:0] view_of(input logic [DW-1:0] w, input bit split, input bit sel);
        if (!split) return w;
        if (!sel)   return {8'h00, w[15:0]};
        return {16'h0000, w[23:16]};
    endfunction

    // Monitor: compare the word driven when the bus turns on
    always @(negedge clk) begin
        if (rst_n && dq_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected drive", dq_out, '0);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(dq_out === e, t, dq_out, e);
            end
        end
        oe_prev = dq_oe;
    end

    // Driver: one read pulse, optionally moving address and select while low (R7)
    task automatic do_read(input int a, input bit sel, input bit split, input string req, input int alt = -1);
        logic [DW-1:0] e;
        e = view_of(model[a], split, sel);
        @(negedge clk);
        addr_in = AW'(a); upper_sel = sel; split_mode = split; rd_n = 1'b0;
        exp_q.push_back(e); tag_q.push_back(req);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(dq_oe == 1'b0, "R9 early drive", {23'd0, dq_oe}, '0);
        @(posedge clk); @(negedge clk);
        check(dq_oe == 1'b1, "R9 late drive", {23'd0, dq_oe}, 24'd1);
        if (alt >= 0) begin
            addr_in = AW'(alt); upper_sel = ~sel;
        end
        repeat (3) @(negedge clk);
        if (alt >= 0) check(dq_out === e, "R7 read target moved", dq_out, e);
        rd_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(dq_oe == 1'b1, "R9 early release", {23'd0, dq_oe}, 24'd1);
        @(posedge clk); @(negedge clk);
        check(dq_oe == 1'b0 && dq_out == '0, "R9 release", dq_out, '0);
        repeat (2) @(negedge clk);
    endtask

    // Driver: one write pulse; late=1 shows junk data first, then moves
    // address and select while low (R7, R8)
    task automatic do_write(input int a, input bit sel, input bit split, input logic [DW-1:0] d, input bit late);
        @(negedge clk);
        addr_in = AW'(a); upper_sel = sel; split_mode = split; wr_n = 1'b0;
        dq_in = late ? ~d : d;
        repeat (2) @(negedge clk);
        if (late) begin
            dq_in = d; addr_in = AW'(a ^ 1); upper_sel = ~sel;
        end
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        if (!split)    model[a] = d;
        else if (!sel) model[a][15:0] = d[15:0];
        else           model[a][23:16] = d[7:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state at the ports
        check(dq_oe == 1'b0 && dq_out == '0, "R10 reset outputs", dq_out, '0);
        // R10 every word reads as zero
        for (int a = 0; a < DEPTH; a++) do_read(a, a[0], 1'b0, "R10 cleared word");
        // R2 full writes with the select toggling
        for (int a = 0; a < DEPTH; a++) do_write(a, a[0], 1'b0, 24'h3C5A96 ^ (24'h010203 * a), 1'b0);
        // R1 full reads with the opposite select
        for (int a = 0; a < DEPTH; a++) do_read(a, ~a[0], 1'b0, "R1 full read");
        // R3 low-field write keeps the high field
        do_write(3, 1'b0, 1'b1, 24'hFFBEEF, 1'b0);
        do_read(3, 1'b0, 1'b0, "R3 low field write");
        // R4 high-field write takes lines 7..0, keeps the low field
        do_write(5, 1'b1, 1'b1, 24'h77AA5C, 1'b0);
        do_read(5, 1'b1, 1'b0, "R4 high field write");
        do_write(DEPTH - 1, 1'b1, 1'b1, 24'h0000E1, 1'b0);
        do_read(DEPTH - 1, 1'b0, 1'b0, "R4 top address");
        // R5 and R6 split reads with zero fill
        do_read(3, 1'b0, 1'b1, "R5 low field read");
        do_read(5, 1'b1, 1'b1, "R6 high field read");
        do_read(3, 1'b1, 1'b1, "R6 high field read");
        do_read(DEPTH - 1, 1'b0, 1'b1, "R5 top address");
        // R7 read target fixed at the falling strobe
        do_read(7, 1'b1, 1'b1, "R7 read capture", 9);
        // R8 last data wins, R7 write target fixed
        do_write(8, 1'b0, 1'b0, 24'h13579B, 1'b1);
        do_read(8, 1'b0, 1'b0, "R8 last data stored");
        do_read(9, 1'b0, 1'b0, "R7 neighbour untouched");
        do_write(10, 1'b0, 1'b1, 24'h00C0DE, 1'b1);
        do_read(10, 1'b0, 1'b0, "R7 split select captured");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 missing drive", DW'(exp_q.size()), '0);
        report();
        $finish;
    end
endmodule